// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link: a bit clock, a frame clock that marks channel or frame boundaries, and a serial data line. It turns the stream into parallel left and right samples. The serial framing is set through static configuration inputs. There are five framings: left justified, right justified, I2S, and two frame-sync variants (early and late). The configuration also gives the word length and the bit-clock edge on which inputs are sampled. All logic runs in the bit-clock domain.

Each sample is shifted in MSB first and presented left aligned in a 32-bit word, with a one-cycle strobe per channel. The receiver also measures the frame-clock period, counted from one rising edge to the next. While that period is exactly 32 bit clocks, it overrides the configured word length with 16 bits. The configuration is expected to change only while reset is asserted.

Top module: `serial_audio_rx`

## Requirements
- R1: `cfg_fmt` selects the framing: 0 left justified, 1 right justified, 2 I2S, 3 frame-sync early, 4 frame-sync late. Codes 5 to 7 produce no strobes.
- R2: `cfg_wlen` selects 16 (0), 20 (1), 24 (2) or 32 (3) bits. Words arrive MSB first. Each sample is output left aligned in a 32-bit word, with all bits below the word length zero.
- R3: With `cfg_fall` 0, the frame clock and data are sampled on the rising bit-clock edge. With `cfg_fall` 1, they are sampled on the falling edge.
- R4: Left justified: the MSB is taken on the first active edge that sees the new frame-clock level. A high level carries the left word and a low level the right word.
- R5: I2S: the MSB is taken one active edge later than in left justified mode, and a low frame clock carries the left word. The LSB may fall on the first edge of the following level.
- R6: Right justified: the LSB is the last bit sampled before a frame-clock transition. The level before the transition names the channel, with high meaning left.
- R7: Right justified with a 32-bit setting is treated as 24 bits.
- R8: Frame-sync modes: a rising frame clock starts a frame. Early mode takes the left MSB on that same edge and late mode one edge later. The right word follows the left word directly.
- R9: Data bits beyond the word length within a channel slot are ignored.
- R10: A measured period of exactly 32 bit clocks between rising frame-clock edges forces 16-bit words. The override stays until a period other than 32 is measured, and the configured length then applies again.
- R11: A strobe is high for one active-edge cycle, with its word valid. The left and right strobes are never high together.
- R12: While and after reset, both words are zero and no strobe is high until a sample completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk | input | 1 | Channel select / frame sync |
| ser_data | input | 1 | Serial audio data, MSB first |
| cfg_fmt | input | 3 | Framing select |
| cfg_wlen | input | 2 | Word length select |
| cfg_fall | input | 1 | 1 = sample on falling bit-clock edge |
| left_word | output | 32 | Last left sample, left aligned |
| left_stb | output | 1 | Left sample valid pulse |
| right_word | output | 32 | Last right sample, left aligned |
| right_stb | output | 1 | Right sample valid pulse |

## Verification
Each framing is driven with distinct left and right patterns. Comparing them separates a channel swap from a bit-order or alignment fault. The unused slot positions are filled with ones, so a capture window that starts one edge early or late shows up as wrong bits. Half-frame lengths longer than the word, and 32-clock frames, check that surplus bits are ignored and that the 16-bit override both engages and releases. Both sampling edges are used. A frame-sync frame that is only just long enough also checks that the right word follows the left word directly.

// File: rtl/sar_pkg.sv
package sar_pkg;
   localparam int WORD_W = 32;

   typedef enum logic [2:0] {
      FMT_LEFT       = 3'd0,
      FMT_RIGHT      = 3'd1,
      FMT_I2S        = 3'd2,
      FMT_SYNC_EARLY = 3'd3,
      FMT_SYNC_LATE  = 3'd4
   } fmt_e;

   typedef enum logic [1:0] {
      WL_16 = 2'd0,
      WL_20 = 2'd1,
      WL_24 = 2'd2,
      WL_32 = 2'd3
   } wlen_e;

   function automatic logic fmt_delayed(input fmt_e f);
      return (f == FMT_I2S) || (f == FMT_SYNC_LATE);
   endfunction

   function automatic logic fmt_sync(input fmt_e f);
      return (f == FMT_SYNC_EARLY) || (f == FMT_SYNC_LATE);
   endfunction
endpackage

// File: rtl/sar_period_meter.sv
// Counts active edges between rising frame-clock edges and holds the
// 16-bit override while the last measured period equals 32.
module sar_period_meter #(
   parameter int CNT_W = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lrc_now,
   input  logic lrc_prev,
   output logic force16
);
   localparam logic [CNT_W-1:0] LAST_OF_32 = CNT_W'(31);
   localparam logic [CNT_W-1:0] CNT_MAX    = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             have_ref_q;
   logic             rise;

   initial begin
      if (CNT_W < 7) $error("sar_period_meter: CNT_W too small");
   end

   assign rise = lrc_now & ~lrc_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         have_ref_q <= 1'b0;
         force16    <= 1'b0;
      end else if (rise) begin
         if (have_ref_q) force16 <= (cnt_q == LAST_OF_32);
         have_ref_q <= 1'b1;
         cnt_q      <= '0;
      end else if (cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sar_len_resolve.sv
// Effective word length from configuration and the period override.
module sar_len_resolve
   import sar_pkg::*;
(
   input  fmt_e        fmt,
   input  wlen_e       wlen,
   input  logic        force16,
   output logic [5:0]  len,
   output logic        fmt_ok
);
   always_comb begin
      fmt_ok = (fmt == FMT_LEFT) || (fmt == FMT_RIGHT) || (fmt == FMT_I2S) ||
               (fmt == FMT_SYNC_EARLY) || (fmt == FMT_SYNC_LATE);
      unique case (wlen)
         WL_16:   len = 6'd16;
         WL_20:   len = 6'd20;
         WL_24:   len = 6'd24;
         default: len = (fmt == FMT_RIGHT) ? 6'd24 : 6'd32;
      endcase
      if (force16) len = 6'd16;
   end
endmodule

// File: rtl/sar_frame_track.sv
// Tracks the bit position since the last reference event. In channel
// modes every level change is an event; in sync modes only a rise.
module sar_frame_track #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_now,
   input  logic             ref_prev,
   input  logic             sync_mode,
   output logic             evt,
   output logic [CNT_W-1:0] pos_now,
   output logic             lvl_now,
   output logic             started_now,
   output logic             started_prev
);
   localparam logic [CNT_W-1:0] POS_MAX = '1;

   logic [CNT_W-1:0] pos_q;
   logic             lvl_q;
   logic             started_q;

   always_comb begin
      evt          = sync_mode ? (ref_now & ~ref_prev) : (ref_now ^ ref_prev);
      pos_now      = evt ? '0 : ((pos_q == POS_MAX) ? pos_q : pos_q + 1'b1);
      lvl_now      = evt ? ref_now : lvl_q;
      started_now  = started_q | evt;
      started_prev = started_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q     <= POS_MAX;
         lvl_q     <= 1'b0;
         started_q <= 1'b0;
      end else begin
         pos_q     <= pos_now;
         lvl_q     <= lvl_now;
         started_q <= started_now;
      end
   end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import sar_pkg::*;
#(
   parameter int MAX_FRAME = 512
) (
   input  logic        bit_clk,
   input  logic        rst_n,
   input  logic        frame_clk,
   input  logic        ser_data,
   input  logic [2:0]  cfg_fmt,
   input  logic [1:0]  cfg_wlen,
   input  logic        cfg_fall,
   output logic [31:0] left_word,
   output logic        left_stb,
   output logic [31:0] right_word,
   output logic        right_stb
);
   localparam int CNT_W = $clog2(MAX_FRAME) + 1;

   initial begin
      if (MAX_FRAME < 64) $error("serial_audio_rx: MAX_FRAME must be at least 64");
      if (WORD_W != 32)   $error("serial_audio_rx: word width must be 32");
   end

   logic              clk_act;
   fmt_e              fmt;
   logic              lrc_q, lrc_qq;
   logic [WORD_W-1:0] sh_q;
   logic              force16;
   logic [5:0]        len;
   logic              fmt_ok;
   logic              ref_now, ref_prev;
   logic              evt, lvl_now, started_now, started_prev;
   logic [CNT_W-1:0]  pos_now;
   logic [CNT_W-1:0]  last_one, last_two;
   logic [5:0]        sh_amt;
   logic [WORD_W-1:0] word_cur, word_old, emit_word;
   logic [1:0]        emit;

   // Active edge: inverting the bit clock turns falling edges into rising ones.
   assign clk_act = bit_clk ^ cfg_fall;
   assign fmt     = fmt_e'(cfg_fmt);

   always_ff @(posedge clk_act or negedge rst_n) begin
      if (!rst_n) begin
         lrc_q  <= 1'b0;
         lrc_qq <= 1'b0;
         sh_q   <= '0;
      end else begin
         lrc_q  <= frame_clk;
         lrc_qq <= lrc_q;
         sh_q   <= {sh_q[WORD_W-2:0], ser_data};
      end
   end

   sar_period_meter #(.CNT_W(CNT_W)) u_meter (
      .clk      (clk_act),
      .rst_n    (rst_n),
      .lrc_now  (frame_clk),
      .lrc_prev (lrc_q),
      .force16  (force16)
   );

   sar_len_resolve u_len (
      .fmt     (fmt),
      .wlen    (wlen_e'(cfg_wlen)),
      .force16 (force16),
      .len     (len),
      .fmt_ok  (fmt_ok)
   );

   // Modes whose MSB trails the reference by one edge see a delayed copy.
   assign ref_now  = fmt_delayed(fmt) ? lrc_q  : frame_clk;
   assign ref_prev = fmt_delayed(fmt) ? lrc_qq : lrc_q;

   sar_frame_track #(.CNT_W(CNT_W)) u_track (
      .clk          (clk_act),
      .rst_n        (rst_n),
      .ref_now      (ref_now),
      .ref_prev     (ref_prev),
      .sync_mode    (fmt_sync(fmt)),
      .evt          (evt),
      .pos_now      (pos_now),
      .lvl_now      (lvl_now),
      .started_now  (started_now),
      .started_prev (started_prev)
   );

   always_comb begin
      sh_amt    = 6'd32 - len;
      word_cur  = {sh_q[WORD_W-2:0], ser_data} << sh_amt;
      word_old  = sh_q << sh_amt;
      last_one  = CNT_W'(len) - 1'b1;
      last_two  = CNT_W'({len, 1'b0}) - 1'b1;
      emit      = 2'b00;
      emit_word = word_cur;
      if (fmt_ok) begin
         unique case (fmt)
            FMT_LEFT, FMT_I2S: begin
               if (started_now && pos_now == last_one) begin
                  if (lvl_now ^ (fmt == FMT_I2S)) emit = 2'b01;
                  else                            emit = 2'b10;
               end
            end
            FMT_RIGHT: begin
               emit_word = word_old;
               if (evt && started_prev) emit = lrc_q ? 2'b01 : 2'b10;
            end
            default: begin
               if (started_now && pos_now == last_one)      emit = 2'b01;
               else if (started_now && pos_now == last_two) emit = 2'b10;
            end
         endcase
      end
   end

   for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      logic [WORD_W-1:0] word_r;
      logic              stb_r;
      always_ff @(posedge clk_act or negedge rst_n) begin
         if (!rst_n) begin
            word_r <= '0;
            stb_r  <= 1'b0;
         end else begin
            stb_r <= emit[ch];
            if (emit[ch]) word_r <= emit_word;
         end
      end
   end

   assign left_word  = g_chan[0].word_r;
   assign left_stb   = g_chan[0].stb_r;
   assign right_word = g_chan[1].word_r;
   assign right_stb  = g_chan[1].stb_r;
endmodule

// File: rtl/sar_rx_checker.sv
module sar_rx_checker (
   input logic        clk,
   input logic        rst_n,
   input logic [2:0]  cfg_fmt,
   input logic [1:0]  cfg_wlen,
   input logic        force16,
   input logic [31:0] left_word,
   input logic        left_stb,
   input logic [31:0] right_word,
   input logic        right_stb
);
   AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      left_stb |-> !right_stb); // R11

   AST_LEFT_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      left_stb |=> !left_stb); // R11

   AST_RIGHT_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      right_stb |=> !right_stb); // R11

   AST_LEFT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (left_stb && cfg_wlen != 2'd3) |-> (left_word[7:0] == 8'd0)); // R2

   AST_RIGHT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (right_stb && cfg_wlen != 2'd3) |-> (right_word[7:0] == 8'd0)); // R2

   AST_FORCE16_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (left_stb && $past(force16)) |-> (left_word[15:0] == 16'd0)); // R10

   AST_RJ_NO32: assert property (@(posedge clk) disable iff (!rst_n)
      (right_stb && cfg_fmt == 3'd1) |-> (right_word[7:0] == 8'd0)); // R7
endmodule

bind serial_audio_rx sar_rx_checker u_sar_chk (
   .clk        (clk_act),
   .rst_n      (rst_n),
   .cfg_fmt    (cfg_fmt),
   .cfg_wlen   (cfg_wlen),
   .force16    (force16),
   .left_word  (left_word),
   .left_stb   (left_stb),
   .right_word (right_word),
   .right_stb  (right_stb)
);

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;
   localparam int NVEC       = 13;

   typedef struct packed {
      logic [2:0]  fmt;
      logic [1:0]  wl;
      logic        fall;
      logic [7:0]  half;
      logic [31:0] lv;
      logic [31:0] rv;
   } vec_t;

   // fmt: 0 LJ, 1 RJ, 2 I2S, 3 sync early, 4 sync late; wl: 0 16, 1 20, 2 24, 3 32
   localparam vec_t VECS [NVEC] = '{
      '{3'd0, 2'd2, 1'b0, 8'd32, 32'hA5C3_9E17, 32'h3C5A_E981},
      '{3'd0, 2'd0, 1'b1, 8'd20, 32'hB7E1_5163, 32'h4D2F_00FF},
      '{3'd0, 2'd3, 1'b0, 8'd32, 32'h8123_4567, 32'h7EDC_BA98},
      '{3'd2, 2'd2, 1'b0, 8'd32, 32'hC0FF_EE12, 32'h1357_9BDF},
      '{3'd2, 2'd1, 1'b1, 8'd24, 32'hE4A7_3B2C, 32'h5B19_D6F0},
      '{3'd1, 2'd2, 1'b0, 8'd32, 32'h9ABC_DEF1, 32'h2468_ACE0},
      '{3'd1, 2'd3, 1'b0, 8'd32, 32'hF00D_CAFE, 32'h0BAD_BEEF},
      '{3'd1, 2'd0, 1'b1, 8'd20, 32'hD5AA_1234, 32'h6E33_8765},
      '{3'd3, 2'd2, 1'b0, 8'd32, 32'hAAAA_5555, 32'h5A5A_A5A5},
      '{3'd4, 2'd0, 1'b0, 8'd20, 32'hCAFE_0000, 32'h71C7_0000},
      '{3'd0, 2'd2, 1'b0, 8'd16, 32'hE1E2_E3E4, 32'h9191_3131},
      '{3'd2, 2'd3, 1'b1, 8'd16, 32'h8765_4321, 32'h4321_8765},
      '{3'd3, 2'd1, 1'b0, 8'd16, 32'hDEAD_BEEF, 32'hB16B_00B5}
   };

   logic        bit_clk = 1'b0;
   logic        rst_n;
   logic        frame_clk;
   logic        ser_data;
   logic [2:0]  cfg_fmt;
   logic [1:0]  cfg_wlen;
   logic        cfg_fall;
   logic [31:0] left_word, right_word;
   logic        left_stb, right_stb;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   int nl, nr, nboth;

   serial_audio_rx u_serial_audio_rx (
      .bit_clk    (bit_clk),
      .rst_n      (rst_n),
      .frame_clk  (frame_clk),
      .ser_data   (ser_data),
      .cfg_fmt    (cfg_fmt),
      .cfg_wlen   (cfg_wlen),
      .cfg_fall   (cfg_fall),
      .left_word  (left_word),
      .left_stb   (left_stb),
      .right_word (right_word),
      .right_stb  (right_stb)
   );

   always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

   always @(posedge bit_clk) begin
      cycles++;
      if (cycles == WATCHDOG) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   task automatic check(input logic ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic edge_idle();
      if (cfg_fall) @(posedge bit_clk);
      else          @(negedge bit_clk);
   endtask

   task automatic do_reset(input logic [2:0] f, input logic [1:0] w, input logic fl);
      rst_n     = 1'b0;
      cfg_fmt   = f;
      cfg_wlen  = w;
      cfg_fall  = fl;
      frame_clk = 1'b0;
      ser_data  = 1'b0;
      repeat (3) edge_idle();
      rst_n = 1'b1;
   endtask

   function automatic int exp_len(input int f, input int w, input int period);
      if (period == 32) return 16;
      case (w)
         0: return 16;
         1: return 20;
         2: return 24;
         default: return (f == 1) ? 24 : 32;
      endcase
   endfunction

   function automatic logic [31:0] top_bits(input logic [31:0] v, input int le);
      logic [31:0] m;
      m = (le >= 32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF >> le);
      return v & m;
   endfunction

   // Returns {frame clock, data} for one bit slot of a frame of 2*h slots.
   function automatic logic [1:0] slot_bits(input int f, input int h, input int le,
                                            input int s, input logic [31:0] lv,
                                            input logic [31:0] rv);
      logic lrc, d;
      int sp, j, k, o;
      logic [31:0] v;
      d = 1'b1;
      if (f == 3 || f == 4) begin
         lrc = (s == 0);
         o   = (f == 4) ? 1 : 0;
         sp  = s - o;
         if (sp >= 0 && sp < le)          d = lv[31-sp];
         else if (sp >= le && sp < 2*le) d = rv[31-(sp-le)];
      end else if (f == 2) begin
         lrc = (s >= h);
         sp  = (s + 2*h - 1) % (2*h);
         v   = (sp >= h) ? rv : lv;
         j   = sp % h;
         if (j < 32) d = v[31-j];
      end else begin
         lrc = (s < h);
         v   = (s >= h) ? rv : lv;
         j   = s % h;
         if (f == 1) begin
            k = j - (h - le);
            if (k >= 0) d = v[31-k];
         end else if (j < 32) begin
            d = v[31-j];
         end
      end
      return {lrc, d};
   endfunction

   task automatic run_frames(input int f, input int w, input int h,
                             input logic [31:0] lv, input logic [31:0] rv,
                             input int nframes, input int skip, input string tag);
      int le;
      logic [1:0] sb;
      le = exp_len(f, w, 2*h);
      nl = 0; nr = 0; nboth = 0;
      for (int fr = 0; fr < nframes; fr++) begin
         for (int s = 0; s < 2*h; s++) begin
            edge_idle();
            if (left_stb && right_stb) nboth++;
            if (left_stb && fr >= skip) begin
               nl++;
               check(left_word == top_bits(lv, le), {tag, " left"}, left_word, top_bits(lv, le));
            end
            if (right_stb && fr >= skip) begin
               nr++;
               check(right_word == top_bits(rv, le), {tag, " right"}, right_word, top_bits(rv, le));
            end
            sb = slot_bits(f, h, le, s, lv, rv);
            frame_clk = sb[1];
            ser_data  = sb[0];
         end
      end
      edge_idle();
   endtask

   function automatic string tag_of(input vec_t v);
      string t;
      int le;
      le = exp_len(int'(v.fmt), int'(v.wl), 2*int'(v.half));
      case (v.fmt)
         3'd0: t = "R4";
         3'd1: t = "R6";
         3'd2: t = "R5";
         default: t = "R8";
      endcase
      t = {t, " R2"};
      if (v.fall) t = {t, " R3"};
      if (int'(v.half) == 16) t = {t, " R10"};
      if (v.fmt == 3'd1 && v.wl == 2'd3) t = {t, " R7"};
      if (v.fmt != 3'd1 && int'(v.half) > le) t = {t, " R9"};
      return t;
   endfunction

   initial begin
      rst_n     = 1'b0;
      cfg_fall  = 1'b0;
      cfg_fmt   = 3'd0;
      cfg_wlen  = 2'd0;
      frame_clk = 1'b0;
      ser_data  = 1'b0;

      // R12: reset state
      do_reset(3'd0, 2'd2, 1'b0);
      edge_idle();
      check(!left_stb && !right_stb, "R12 strobes after reset",
            {30'd0, left_stb, right_stb}, 32'd0);
      check(left_word == 32'd0, "R12 left word after reset", left_word, 32'd0);
      check(right_word == 32'd0, "R12 right word after reset", right_word, 32'd0);

      // Table walk: every framing, length and edge
      for (int i = 0; i < NVEC; i++) begin
         do_reset(VECS[i].fmt, VECS[i].wl, VECS[i].fall);
         run_frames(int'(VECS[i].fmt), int'(VECS[i].wl), int'(VECS[i].half),
                    VECS[i].lv, VECS[i].rv, 6, 2, tag_of(VECS[i]));
         check(nl >= 3 && nr >= 3, {tag_of(VECS[i]), " strobe count"},
               32'(nl * 256 + nr), 32'(3 * 256 + 3));
         check(nboth == 0, "R11 strobes never together", 32'(nboth), 32'd0);
      end

      // R10: override engages on 32-clock frames, then releases on longer ones
      do_reset(3'd0, 2'd2, 1'b0);
      run_frames(0, 2, 16, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 5, 2, "R10 engaged");
      check(nl >= 2, "R10 engaged strobes", 32'(nl), 32'd2);
      run_frames(0, 2, 24, 32'hFEDC_BA98, 32'h1234_5678, 6, 2, "R10 released");
      check(nl >= 3 && nr >= 3, "R10 released strobes", 32'(nl * 256 + nr), 32'(3 * 256 + 3));

      // R1: undefined format code produces nothing
      do_reset(3'd5, 2'd0, 1'b0);
      run_frames(0, 0, 20, 32'hFFFF_0000, 32'h0000_FFFF, 4, 0, "R1 undefined format");
      check(nl == 0 && nr == 0, "R1 no strobes for code 5", 32'(nl + nr), 32'd0);
      check(left_word == 32'd0 && right_word == 32'd0, "R1 words stay zero",
            left_word | right_word, 32'd0);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end
endmodule